// File: doc/BRIEF.md
# Two-Level Leading-One Locator

This block finds the most significant set bit of a 52-bit significand and reports it as a count of leading zeros, measured from the top bit. A floating-point adder uses this count to normalize the raw difference after a subtraction. The shifter that applies the count belongs to the adder and is not part of this block.

The input is cut into thirteen 4-bit slices. Slice 0 holds the four highest bits. Each slice has a small encoder that reports two things: whether the slice holds any set bit, and how deep the first set bit sits inside it. A second-level encoder reads the thirteen "slice busy" flags and picks the highest busy slice. A multiplexer then takes that slice's local depth, and the slice's base offset (a multiple of four) is added to it.

When no bit is set, a zero flag is raised and the count reads 52. The result always leaves through a register. A parameter can place one more register between the two levels, which adds one cycle of latency. The block accepts a new input on every cycle.

Top module: `msb_locator`

## Requirements
- R1: For a nonzero input, `count_o` equals the number of zero bits above the highest set bit, counted from bit 51; an input with bit 51 set gives 0 and an input whose highest set bit is bit 0 gives 51.
- R2: For an all-zero input, `zero_o` is 1 and `count_o` is 52.
- R3: For any nonzero input, `zero_o` is 0.
- R4: Bits below the highest set bit have no effect on `count_o` or `zero_o`.
- R5: With `MID_REG` = 0, the result for an input sampled at a rising edge appears after that edge. With `MID_REG` = 1, it appears one edge later.
- R6: While `rst_n` is low and right after reset, the outputs read `zero_o` = 1 and `count_o` = 52.
- R7: A new input can be applied on every clock cycle, and each result depends only on its own input, whatever the inputs before or after it.
- R8: A leading one at the top bit of a slice and a leading one at the bottom bit of the slice above it give counts that differ by exactly one. For example, 0x0800000000000 gives 4 and 0x1000000000000 gives 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| data_i | input | 52 | Significand to scan; bit 51 is the most significant |
| count_o | output | 6 | Leading-zero count, 0 to 52 |
| zero_o | output | 1 | High when the scanned input had no set bit |

## Verification
Two things can happen in the same cycle: the second level emits the result for one input while the first level takes in the next one. The bench drives a fresh value every cycle, including all-zero values between nonzero ones. It then checks that each output matches the input applied one cycle earlier (flat build) or two cycles earlier (registered build), and never the input that was captured alongside it. A separate step changes the input once and samples both builds after a single edge, which shows that the flat build has already moved while the registered build still shows the old result.

// File: rtl/lod_pkg.sv
package lod_pkg;

    localparam int DEF_DATA_W = 52;
    localparam int DEF_GRP_W  = 4;

    // Base bit distance from the MSB for a slice index.
    function automatic int slice_base(input int idx, input int grp_w);
        return idx * grp_w;
    endfunction

endpackage

// File: rtl/lod_slice_enc.sv
module lod_slice_enc #(
    parameter int GRP_W = 4,
    localparam int LCL_W = (GRP_W > 1) ? $clog2(GRP_W) : 1
) (
    input  logic [GRP_W-1:0] bits_i,
    output logic             busy_o,
    output logic [LCL_W-1:0] depth_o
);

    always_comb begin
        busy_o  = |bits_i;
        depth_o = '0;
        // Scan upward so the highest set bit overwrites the rest.
        for (int i = 0; i < GRP_W; i++) begin
            if (bits_i[i]) begin
                depth_o = LCL_W'(GRP_W - 1 - i);
            end
        end
    end

endmodule

// File: rtl/lod_slice_pick.sv
module lod_slice_pick #(
    parameter int NGRP = 13,
    localparam int GI_W = (NGRP > 1) ? $clog2(NGRP) : 1
) (
    input  logic [NGRP-1:0] busy_i,
    output logic [GI_W-1:0] idx_o,
    output logic            none_o
);

    always_comb begin
        none_o = ~|busy_i;
        idx_o  = '0;
        // Scan from the least significant slice so index 0 wins last.
        for (int g = NGRP - 1; g >= 0; g--) begin
            if (busy_i[g]) begin
                idx_o = GI_W'(g);
            end
        end
    end

endmodule

// File: rtl/msb_locator.sv
module msb_locator #(
    parameter int DATA_W  = lod_pkg::DEF_DATA_W,
    parameter int GRP_W   = lod_pkg::DEF_GRP_W,
    parameter bit MID_REG = 1'b1,
    localparam int NGRP  = DATA_W / GRP_W,
    localparam int LCL_W = (GRP_W > 1) ? $clog2(GRP_W) : 1,
    localparam int GI_W  = (NGRP > 1) ? $clog2(NGRP) : 1,
    localparam int CNT_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              zero_o
);

    typedef struct packed {
        logic [NGRP-1:0]       busy;
        logic [NGRP*LCL_W-1:0] depth;
    } mid_t;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             zero;
    } res_t;

    logic [NGRP-1:0]       slice_busy;
    logic [NGRP*LCL_W-1:0] slice_depth;
    mid_t                  mid_d, mid_q;
    res_t                  res_d, res_q;
    logic [GI_W-1:0]       win_idx;
    logic                  win_none;

    // First level: one encoder per slice; slice 0 is the top of data_i.
    for (genvar g = 0; g < NGRP; g++) begin : g_slice
        localparam int HI = DATA_W - 1 - g * GRP_W;
        lod_slice_enc #(.GRP_W(GRP_W)) u_enc (
            .bits_i  (data_i[HI -: GRP_W]),
            .busy_o  (slice_busy[g]),
            .depth_o (slice_depth[g*LCL_W +: LCL_W])
        );
    end

    always_comb begin
        mid_d.busy  = slice_busy;
        mid_d.depth = slice_depth;
    end

    // Optional register between the levels.
    if (MID_REG) begin : g_mid_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mid_q <= '0;
            end else begin
                mid_q <= mid_d;
            end
        end
    end else begin : g_mid_flat
        always_comb mid_q = mid_d;
    end

    // Second level: pick the highest busy slice.
    lod_slice_pick #(.NGRP(NGRP)) u_pick (
        .busy_i (mid_q.busy),
        .idx_o  (win_idx),
        .none_o (win_none)
    );

    always_comb begin
        logic [LCL_W-1:0] sel_depth;
        sel_depth = '0;
        for (int g = 0; g < NGRP; g++) begin
            if (win_idx == GI_W'(g)) begin
                sel_depth = mid_q.depth[g*LCL_W +: LCL_W];
            end
        end
        if (win_none) begin
            res_d.count = CNT_W'(DATA_W);
            res_d.zero  = 1'b1;
        end else begin
            res_d.count = CNT_W'(lod_pkg::slice_base(int'(win_idx), GRP_W)
                                 + int'(sel_depth));
            res_d.zero  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q.count <= CNT_W'(DATA_W);
            res_q.zero  <= 1'b1;
        end else begin
            res_q <= res_d;
        end
    end

    assign count_o = res_q.count;
    assign zero_o  = res_q.zero;

endmodule

// File: rtl/lod_chk.sv
module lod_chk #(
    parameter int DATA_W = 52,
    parameter int LAT    = 2,
    localparam int CNT_W = $clog2(DATA_W + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] data_i,
    input logic [CNT_W-1:0]  count_o,
    input logic              zero_o
);

    logic [DATA_W-1:0] hist1, hist2, seen;
    logic              lead_set, upper_clear;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist1 <= '0;
            hist2 <= '0;
        end else begin
            hist1 <= data_i;
            hist2 <= hist1;
        end
    end

    always_comb begin
        int li;
        seen = (LAT == 2) ? hist2 : hist1;
        li   = DATA_W - 1 - int'(count_o);
        lead_set    = (li >= 0 && li < DATA_W) ? seen[li] : 1'b0;
        upper_clear = (count_o == '0) ? 1'b1
                    : ((seen >> (DATA_W - int'(count_o))) == '0);
    end

    p_leading_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !zero_o |-> lead_set);

    p_above_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !zero_o |-> upper_clear);

    p_zero_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        zero_o |-> (count_o == CNT_W'(DATA_W)));

    p_zero_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        zero_o == (seen == '0));

    p_count_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !zero_o |-> (count_o < CNT_W'(DATA_W)));

endmodule

bind msb_locator lod_chk #(
    .DATA_W (DATA_W),
    .LAT    (MID_REG ? 2 : 1)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .data_i  (data_i),
    .count_o (count_o),
    .zero_o  (zero_o)
);

// File: tb/msb_locator_test.sv
module msb_locator_test;

    localparam int DW = 52;
    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] data = '0;
    logic [CW-1:0] cnt_reg, cnt_flat;
    logic          z_reg, z_flat;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    msb_locator #(.MID_REG(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .data_i(data),
        .count_o(cnt_reg), .zero_o(z_reg)
    );

    msb_locator #(.MID_REG(1'b0)) uut_flat (
        .clk(clk), .rst_n(rst_n), .data_i(data),
        .count_o(cnt_flat), .zero_o(z_flat)
    );

    // {input, expected count}
    localparam logic [DW+CW-1:0] TBL [14] = '{
        {52'h8000000000000, 6'd0},
        {52'hFFFFFFFFFFFFF, 6'd0},
        {52'h4000000000000, 6'd1},
        {52'h1000000000000, 6'd3},
        {52'h0800000000000, 6'd4},
        {52'h00F0000000000, 6'd8},
        {52'h0123456789ABC, 6'd7},
        {52'h0000001000000, 6'd27},
        {52'h0000000000010, 6'd47},
        {52'h000000000000F, 6'd48},
        {52'h0000000000008, 6'd48},
        {52'h0000000000007, 6'd49},
        {52'h0000000000001, 6'd51},
        {52'h0000000000000, 6'd52}
    };

    function automatic int ref_lzc(input logic [DW-1:0] v);
        int r = DW;
        for (int i = 0; i < DW; i++) begin
            if (v[i]) r = DW - 1 - i;
        end
        return r;
    endfunction

    task automatic check(input string req, input string who,
                         input logic [CW-1:0] got_c, input logic got_z,
                         input int exp_c);
        logic exp_z;
        exp_z = (exp_c == DW);
        n_cmp++;
        if (got_c != CW'(exp_c) || got_z != exp_z) begin
            n_bad++;
            $display("FAIL %s %s: count=%0d zero=%0b expected count=%0d zero=%0b",
                     req, who, got_c, got_z, exp_c, exp_z);
        end
    endtask

    // Hold value for both builds to settle, then compare both.
    task automatic apply_steady(input logic [DW-1:0] v, input int exp_c,
                                input string req);
        @(negedge clk);
        data = v;
        @(negedge clk);
        @(negedge clk);
        check(req, "registered", cnt_reg, z_reg, exp_c);
        check(req, "flat", cnt_flat, z_flat, exp_c);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        finish_run();
    end

    initial begin
        logic [DW-1:0] hist [3];
        // R6: reset state
        repeat (3) @(negedge clk);
        check("R6", "registered", cnt_reg, z_reg, DW);
        check("R6", "flat", cnt_flat, z_flat, DW);
        data = 52'hABCDE12345678;
        @(negedge clk);
        check("R6", "registered-held", cnt_reg, z_reg, DW);
        rst_n = 1'b1;

        // R1 R2 R3 R4 R8: vector table
        for (int k = 0; k < 14; k++) begin
            apply_steady(TBL[k][DW+CW-1:CW], int'(TBL[k][CW-1:0]),
                         (k == 4 || k == 3) ? "R8" : "R1/R2/R3/R4");
        end

        // R1: each single-bit position
        for (int i = 0; i < DW; i++) begin
            apply_steady(DW'(1) << i, DW - 1 - i, "R1");
        end

        // R4 R3: random values with junk below the leading one
        for (int k = 0; k < 60; k++) begin
            logic [DW-1:0] v;
            v = DW'({$urandom, $urandom}) >> ($urandom % 53);
            apply_steady(v, ref_lzc(v), "R4");
        end

        // R5: one-cycle lag between the builds
        apply_steady(52'h0000000000001, 51, "R5");
        @(negedge clk);
        data = 52'h0400000000000;
        @(negedge clk);
        check("R5", "flat-after-1", cnt_flat, z_flat, 5);
        check("R5", "registered-after-1", cnt_reg, z_reg, 51);
        @(negedge clk);
        check("R5", "registered-after-2", cnt_reg, z_reg, 5);

        // R7: new input every cycle, zeros interleaved
        for (int j = 0; j < 3; j++) hist[j] = data;
        for (int n = 0; n < 40; n++) begin
            logic [DW-1:0] v;
            v = (n % 5 == 2) ? '0 : DW'({$urandom, $urandom}) >> ($urandom % 53);
            data = v;
            hist[2] = hist[1];
            hist[1] = hist[0];
            hist[0] = v;
            @(negedge clk);
            check("R7", "flat-stream", cnt_flat, z_flat, ref_lzc(hist[0]));
            check("R7", "registered-stream", cnt_reg, z_reg, ref_lzc(hist[1]));
        end

        finish_run();
    end

endmodule